// File: doc/BRIEF.md
# Four-Channel Match Timer

This block holds four 32-bit counters that run from a common clock and share one prescale setting. Each channel has its own enable, its own synchronous clear, a count direction, and a match value. When a running counter reaches its match value it can, depending on three per-channel action bits, raise an interrupt flag, reload itself with zero, and switch itself off. This covers both periodic ticks (reload on match) and single-shot timeouts (stop on match).

Software reaches every setting through a flat word-addressed register port. Writes take effect on the rising edge where `wr_en` is high, and reads are combinational from `addr`. Interrupt flags are sticky and are cleared by writing 1 to them. The single `irq` output is high while any flag is set. Counters wrap silently in both directions. The address map assumes `NUM_CH` is at most 4.

Top module: `quad_match_timer`

## Requirements
- R1: After reset every register reads 0, every counter and prescale count is 0, and `irq` is 0.
- R2: Address 0 is the control word. Bit n (0..3) enables channel n, and bit 4+n is that channel's clear bit. An enabled channel counts, and a disabled channel that is not being cleared holds its count. Counts read at address 8+n.
- R3: While clear bit n is set, channel n's counter and prescale count are forced to 0 on each rising edge, starting with the edge after the write.
- R4: The prescale setting at address 2 is shared by all channels. With value P, an enabled channel advances once every P+1 clocks, so P=0 advances every clock. Channel n's prescale count reads at address 16+n.
- R5: The direction word at address 1 uses bit 4n for channel n: 0 counts up and 1 counts down. All other bits read 0.
- R6: Counting up wraps 0xFFFFFFFF to 0, and counting down wraps 0 to 0xFFFFFFFF. A wrap raises no flag.
- R7: The action word at address 3 gives channel n bits 3n (flag), 3n+1 (reload) and 3n+2 (stop). A match occurs on the edge where an enabled, uncleared channel would advance while its count equals its match value. With bit 3n set, that edge sets flag n, and `irq` is the OR of the flags.
- R8: With bit 3n+1 set, a match loads 0 into the counter instead of the next value.
- R9: With bit 3n+2 set, a match clears enable bit n and the counter keeps the match value. When both bit 3n+1 and bit 3n+2 are set, the counter loads 0 and the channel stops.
- R10: The status word at address 4 holds flag n in bit n and reads 0 in bit 4. Writing 1 clears a flag, and writing 0 leaves it. A match on the same edge as a clearing write leaves the flag set.
- R11: Match values are read and written at address 12+n. Every address that is not listed reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W (5) | Word address for reads and writes |
| wdata | input | CNT_W (32) | Write data |
| rdata | output | CNT_W (32) | Combinational read data for `addr` |
| irq | output | 1 | High while any match flag is set |

## Verification
A register write is visible on `rdata` just after the edge that captures it. A counter first moves on the edge after the write that enables it. A match flag and `irq` rise on the edge where the counter leaves its match value, and the reload or stop takes effect on that same edge. The bench runs a behavioural model of the registers, and after every rising edge, once the design and the model have both updated, it compares `rdata` for the current address and `irq` against the model. Hand-computed directed reads are taken half a nanosecond after a falling edge. Each of these reads counts every edge since the write that caused it.

// File: rtl/qmt_pkg.sv
`timescale 1ns/1ps
package qmt_pkg;
    // word addresses
    localparam int ADR_CTRL  = 0;
    localparam int ADR_DIR   = 1;
    localparam int ADR_PRE   = 2;
    localparam int ADR_ACT   = 3;
    localparam int ADR_STAT  = 4;
    localparam int ADR_CNT   = 8;
    localparam int ADR_MATCH = 12;
    localparam int ADR_PCNT  = 16;
    // field layout
    localparam int DIR_STRIDE = 4;
    localparam int ACT_W      = 3;
    localparam int ACT_FLAG   = 0;
    localparam int ACT_RELOAD = 1;
    localparam int ACT_STOP   = 2;
endpackage

// File: rtl/qmt_channel.sv
`timescale 1ns/1ps
module qmt_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic             down_i,
    input  logic [CNT_W-1:0] pre_i,
    input  logic [CNT_W-1:0] match_i,
    input  logic             act_reload_i,
    input  logic             act_stop_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] pc_o,
    output logic             hit_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] pc;
    } ch_state_t;

    ch_state_t q, d;
    logic      tick;

    always_comb begin
        d     = q;
        tick  = (q.pc >= pre_i);
        hit_o = en_i && !clr_i && tick && (q.cnt == match_i);
        if (clr_i) begin
            d = '0;
        end else if (en_i) begin
            if (tick) begin
                d.pc = '0;
                if (hit_o && act_reload_i) begin
                    d.cnt = '0;
                end else if (hit_o && act_stop_i) begin
                    d.cnt = q.cnt;
                end else if (down_i) begin
                    d.cnt = q.cnt - 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else begin
                d.pc = q.pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt_o = q.cnt;
    assign pc_o  = q.pc;
endmodule

// File: rtl/qmt_rdmux.sv
`timescale 1ns/1ps
module qmt_rdmux
    import qmt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic [NUM_CH-1:0]              en,
    input  logic [NUM_CH-1:0]              clr,
    input  logic [NUM_CH-1:0]              down,
    input  logic [CNT_W-1:0]               pre,
    input  logic [ACT_W*NUM_CH-1:0]        act,
    input  logic [NUM_CH-1:0]              flag,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   match,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   pc,
    output logic [CNT_W-1:0]               rdata
);
    localparam int ACT_BITS = ACT_W * NUM_CH;

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_CTRL)) begin
            rdata[NUM_CH-1:0]        = en;
            rdata[2*NUM_CH-1:NUM_CH] = clr;
        end
        if (addr == ADDR_W'(ADR_DIR)) begin
            for (int n = 0; n < NUM_CH; n++) rdata[DIR_STRIDE*n] = down[n];
        end
        if (addr == ADDR_W'(ADR_PRE))  rdata = pre;
        if (addr == ADDR_W'(ADR_ACT))  rdata[ACT_BITS-1:0] = act;
        if (addr == ADDR_W'(ADR_STAT)) rdata[NUM_CH-1:0] = flag;
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == ADDR_W'(ADR_CNT + n))   rdata = cnt[n];
            if (addr == ADDR_W'(ADR_MATCH + n)) rdata = match[n];
            if (addr == ADDR_W'(ADR_PCNT + n))  rdata = pc[n];
        end
    end
endmodule

// File: rtl/quad_match_timer.sv
`timescale 1ns/1ps
module quad_match_timer
    import qmt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              irq
);
    localparam int ACT_BITS = ACT_W * NUM_CH;

    typedef struct packed {
        logic [NUM_CH-1:0]            en;
        logic [NUM_CH-1:0]            clr;
        logic [NUM_CH-1:0]            down;
        logic [CNT_W-1:0]             pre;
        logic [ACT_BITS-1:0]          act;
        logic [NUM_CH-1:0]            flag;
        logic [NUM_CH-1:0][CNT_W-1:0] match;
    } regs_t;

    regs_t q, d;

    logic [NUM_CH-1:0]            hit;
    logic [NUM_CH-1:0][CNT_W-1:0] cnt;
    logic [NUM_CH-1:0][CNT_W-1:0] pc;

    always_comb begin
        d = q;
        if (wr_en) begin
            if (addr == ADDR_W'(ADR_CTRL)) begin
                d.en  = wdata[NUM_CH-1:0];
                d.clr = wdata[2*NUM_CH-1:NUM_CH];
            end
            if (addr == ADDR_W'(ADR_DIR)) begin
                for (int n = 0; n < NUM_CH; n++) d.down[n] = wdata[DIR_STRIDE*n];
            end
            if (addr == ADDR_W'(ADR_PRE))  d.pre  = wdata;
            if (addr == ADDR_W'(ADR_ACT))  d.act  = wdata[ACT_BITS-1:0];
            if (addr == ADDR_W'(ADR_STAT)) d.flag = q.flag & ~wdata[NUM_CH-1:0];
            for (int n = 0; n < NUM_CH; n++) begin
                if (addr == ADDR_W'(ADR_MATCH + n)) d.match[n] = wdata;
            end
        end
        // match actions win over a same-edge software write
        for (int n = 0; n < NUM_CH; n++) begin
            if (hit[n] && q.act[ACT_W*n + ACT_STOP]) d.en[n]   = 1'b0;
            if (hit[n] && q.act[ACT_W*n + ACT_FLAG]) d.flag[n] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        qmt_channel #(.CNT_W(CNT_W)) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .en_i         (q.en[g]),
            .clr_i        (q.clr[g]),
            .down_i       (q.down[g]),
            .pre_i        (q.pre),
            .match_i      (q.match[g]),
            .act_reload_i (q.act[ACT_W*g + ACT_RELOAD]),
            .act_stop_i   (q.act[ACT_W*g + ACT_STOP]),
            .cnt_o        (cnt[g]),
            .pc_o         (pc[g]),
            .hit_o        (hit[g])
        );
    end

    qmt_rdmux #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
        .addr  (addr),
        .en    (q.en),
        .clr   (q.clr),
        .down  (q.down),
        .pre   (q.pre),
        .act   (q.act),
        .flag  (q.flag),
        .match (q.match),
        .cnt   (cnt),
        .pc    (pc),
        .rdata (rdata)
    );

    assign irq = |q.flag;

    // plain views for the bound checker
    logic [NUM_CH-1:0]   en_view, clr_view, flag_view;
    logic [ACT_BITS-1:0] act_view;
    assign en_view   = q.en;
    assign clr_view  = q.clr;
    assign flag_view = q.flag;
    assign act_view  = q.act;
endmodule

// File: rtl/qmt_checker.sv
`timescale 1ns/1ps
module qmt_checker
    import qmt_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0]            en,
    input logic [NUM_CH-1:0]            clr,
    input logic [NUM_CH-1:0]            flag,
    input logic [NUM_CH-1:0]            hit,
    input logic [ACT_W*NUM_CH-1:0]      act,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt
);
    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
            clr[n] |=> (cnt[n] == '0));
        a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[n] && !clr[n]) |=> $stable(cnt[n]));
        a_r8_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[n] && act[ACT_W*n + ACT_RELOAD]) |=> (cnt[n] == '0));
        a_r9_stop_disables: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[n] && act[ACT_W*n + ACT_STOP]) |=> !en[n]);
        a_r7_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[n]) |-> $past(hit[n] && act[ACT_W*n + ACT_FLAG]));
    end
endmodule

bind quad_match_timer qmt_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en_view),
    .clr   (clr_view),
    .flag  (flag_view),
    .hit   (hit),
    .act   (act_view),
    .cnt   (cnt)
);

// File: tb/sim_quad_match_timer.sv
`timescale 1ns/1ps
module sim_quad_match_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int failed = 0;
    bit done = 0;

    always #2 clk = ~clk;

    quad_match_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                         .wdata(wdata), .rdata(rdata), .irq(irq));

    // ---------------- behavioural reference ----------------
    logic [31:0] m_cnt [4];
    logic [31:0] m_pc  [4];
    logic [31:0] m_match [4];
    logic [3:0]  m_en, m_clr, m_down, m_flag;
    logic [31:0] m_pre;
    logic [11:0] m_act;

    task automatic m_step();
        bit          hitv [4];
        logic [31:0] nc [4];
        logic [31:0] np [4];
        if (!rst_n) begin
            for (int n = 0; n < 4; n++) begin
                m_cnt[n] = 0; m_pc[n] = 0; m_match[n] = 0;
            end
            m_en = 0; m_clr = 0; m_down = 0; m_flag = 0; m_pre = 0; m_act = 0;
            return;
        end
        for (int n = 0; n < 4; n++) begin
            bit tk;
            tk = (m_pc[n] >= m_pre);
            hitv[n] = m_en[n] && !m_clr[n] && tk && (m_cnt[n] == m_match[n]);
            nc[n] = m_cnt[n];
            np[n] = m_pc[n];
            if (m_clr[n]) begin
                nc[n] = 0; np[n] = 0;
            end else if (m_en[n]) begin
                if (tk) begin
                    np[n] = 0;
                    if (hitv[n] && m_act[3*n+1])      nc[n] = 0;
                    else if (hitv[n] && m_act[3*n+2]) nc[n] = m_cnt[n];
                    else if (m_down[n])               nc[n] = m_cnt[n] - 1;
                    else                              nc[n] = m_cnt[n] + 1;
                end else begin
                    np[n] = m_pc[n] + 1;
                end
            end
        end
        if (wr_en) begin
            case (addr)
                5'd0: begin m_en = wdata[3:0]; m_clr = wdata[7:4]; end
                5'd1: m_down = {wdata[12], wdata[8], wdata[4], wdata[0]};
                5'd2: m_pre = wdata;
                5'd3: m_act = wdata[11:0];
                5'd4: m_flag = m_flag & ~wdata[3:0];
                5'd12, 5'd13, 5'd14, 5'd15: m_match[addr-12] = wdata;
                default: ;
            endcase
        end
        for (int n = 0; n < 4; n++) begin
            if (hitv[n] && m_act[3*n+2]) m_en[n] = 1'b0;
            if (hitv[n] && m_act[3*n])   m_flag[n] = 1'b1;
            m_cnt[n] = nc[n];
            m_pc[n]  = np[n];
        end
    endtask

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a)
            5'd0: return {24'd0, m_clr, m_en};
            5'd1: return {19'd0, m_down[3], 3'd0, m_down[2], 3'd0, m_down[1], 3'd0, m_down[0]};
            5'd2: return m_pre;
            5'd3: return {20'd0, m_act};
            5'd4: return {28'd0, m_flag};
            5'd8, 5'd9, 5'd10, 5'd11: return m_cnt[a-8];
            5'd12, 5'd13, 5'd14, 5'd15: return m_match[a-12];
            5'd16, 5'd17, 5'd18, 5'd19: return m_pc[a-16];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [4:0] a);
        if (a == 0 || (a >= 8 && a <= 11)) return "R2";
        if (a == 1) return "R5";
        if (a == 2 || (a >= 16 && a <= 19)) return "R4";
        if (a == 3) return "R7";
        if (a == 4) return "R10";
        return "R11";
    endfunction

    always @(posedge clk) begin
        m_step();
        #1;
        if (rst_n && !done) begin
            total++;
            if (rdata !== m_read(addr)) begin
                failed++;
                $display("FAIL %s model addr %0d actual %h expected %h",
                         tag_of(addr), addr, rdata, m_read(addr));
            end
            total++;
            if (irq !== (|m_flag)) begin
                failed++;
                $display("FAIL R7 model irq actual %b expected %b", irq, |m_flag);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #0.5;
        total++;
        if (rdata !== exp) begin
            failed++;
            $display("FAIL %s addr %0d actual %h expected %h", req, a, rdata, exp);
        end
    endtask

    task automatic chk_irq(input logic exp, input string req);
        total++;
        if (irq !== exp) begin
            failed++;
            $display("FAIL %s irq actual %b expected %b", req, irq, exp);
        end
    endtask

    logic [31:0] held;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(5'd0, 32'h0, "R1");
        chk_irq(1'b0, "R1");
        rd(5'd8, 32'h0, "R1");
        rd(5'd4, 32'h0, "R1");

        // R2: enable channel 0, up, no prescale
        wr(5'd0, 32'h1);
        repeat (9) @(negedge clk);
        rd(5'd8, 32'd10, "R2");
        // R2: disabled channel holds
        wr(5'd0, 32'h0);
        @(negedge clk); addr = 5'd8; #0.5; held = rdata;
        repeat (5) @(negedge clk);
        rd(5'd8, held, "R2");

        // R3: clear bit forces zero and keeps it
        wr(5'd0, 32'h10);
        rd(5'd8, 32'h0, "R3");
        rd(5'd16, 32'h0, "R3");
        repeat (3) @(negedge clk);
        rd(5'd8, 32'h0, "R3");

        // R4: prescale 2 -> one step every 3 clocks
        wr(5'd2, 32'd2);
        wr(5'd0, 32'h1);
        repeat (8) @(negedge clk);
        rd(5'd8, 32'd3, "R4");
        rd(5'd16, 32'd1, "R4");

        // R5 / R6: count down from zero wraps with no flag
        wr(5'd0, 32'h10);
        wr(5'd3, 32'h1);
        wr(5'd12, 32'd5);
        wr(5'd2, 32'd0);
        wr(5'd1, 32'h1);
        wr(5'd0, 32'h1);
        repeat (2) @(negedge clk);
        rd(5'd8, 32'hFFFF_FFFD, "R6");
        rd(5'd4, 32'h0, "R6");
        chk_irq(1'b0, "R6");
        rd(5'd1, 32'h1, "R5");

        // R7 / R8: channel 1 periodic with match 3
        wr(5'd0, 32'h0);
        wr(5'd1, 32'h0);
        wr(5'd13, 32'd3);
        wr(5'd3, 32'h18);
        wr(5'd0, 32'h2);
        repeat (2) @(negedge clk);
        rd(5'd9, 32'd3, "R8");
        chk_irq(1'b0, "R7");
        rd(5'd9, 32'd0, "R8");
        rd(5'd4, 32'h2, "R7");
        chk_irq(1'b1, "R7");
        // R10: write-one clear
        wr(5'd0, 32'h0);
        wr(5'd4, 32'h2);
        rd(5'd4, 32'h0, "R10");
        chk_irq(1'b0, "R10");

        // R9: channel 2 stops on match 4
        wr(5'd14, 32'd4);
        wr(5'd3, 32'h140);
        wr(5'd0, 32'h4);
        repeat (9) @(negedge clk);
        rd(5'd0, 32'h0, "R9");
        rd(5'd10, 32'd4, "R9");
        rd(5'd4, 32'h4, "R7");
        wr(5'd4, 32'h0);
        rd(5'd4, 32'h4, "R10");
        wr(5'd4, 32'h14);
        rd(5'd4, 32'h0, "R10");

        // R11 / R5: field readback and unmapped space
        wr(5'd1, 32'hFFFF_FFFF);
        rd(5'd1, 32'h0000_1111, "R5");
        wr(5'd3, 32'hFFFF_FFFF);
        rd(5'd3, 32'h0000_0FFF, "R11");
        rd(5'd14, 32'd4, "R11");
        rd(5'd20, 32'h0, "R11");
        rd(5'd6, 32'h0, "R11");

        // mixed run against the model: all channels, R6 R8 R9 R10 races
        wr(5'd0, 32'hF0);
        wr(5'd2, 32'd1);
        wr(5'd1, 32'h0101);
        wr(5'd12, 32'hFFFF_FFF0);
        wr(5'd13, 32'd7);
        wr(5'd14, 32'hFFFF_FFFA);
        wr(5'd15, 32'd5);
        wr(5'd3, 32'hACB);
        wr(5'd0, 32'h0F);
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (i % 13 == 0) begin
                wr_en = 1'b1; addr = 5'd4; wdata = $urandom & 32'hF;
            end else begin
                int k;
                k = i % 17;
                wr_en = 1'b0;
                addr = (k < 5) ? 5'(k) : 5'(k + 3);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
        // R9: channel 3 is off after its stop-on-match
        rd(5'd0, 32'h7, "R9");

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            done = 1;
            total++;
            failed++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end
endmodule